// File: doc/BRIEF.md
# SCSI Selection Detector and Interrupt Collector

This block watches the filtered SCSI control lines and decides when the device has been selected or reselected. A selection counts only when select is asserted, busy is deasserted and at least one data-bus ID bit hits the select-enable mask, and all three conditions must hold without a break for a programmable number of clock cycles. The I/O line at the moment of detection decides whether the event is recorded as a selection or as a reselection. When parity checking is enabled in the mode word, a parity error seen during the selection window is latched into a separate status bit.

The block also collects the other interrupt causes into one active-high IRQ line. These are end-of-process during DMA, a bus reset, a data-phase parity error, a phase mismatch and a disconnect, and each one is gated by its own enable. Every cause sets its own sticky status bit, so software can find the source of an interrupt. The status is cleared by a host read strobe, or by an external reset input that has been held for a minimum number of cycles.

Top module: `scsi_sel_irq`

## Requirements
- R1: After reset, all `stat_o` bits and `irq_o` are 0.
- R2: If `sel_i`=1, `bsy_i`=0 and `(id_i & sel_en_i)`≠0 hold for SETTLE_CYC consecutive rising edges, then on the last of those edges a selection is detected. With `io_i`=0 this sets `stat_o[0]`, and `irq_o` then reads 1.
- R3: A single overlapping bit between `id_i` and `sel_en_i` is enough to qualify. Any number of overlapping bits also qualifies. No overlap never qualifies.
- R4: If `io_i`=1 on the detecting edge, `stat_o[1]` (reselection) is set instead of `stat_o[0]`.
- R5: When `sel_en_i` is all zeros, neither `stat_o[0]` nor `stat_o[1]` is ever set.
- R6: Any cycle in which one of the R2 conditions is missing restarts the settle count from zero.
- R7: A selection is detected at most once per assertion of `sel_i`. Detection re-arms only after an edge with `sel_i`=0.
- R8: If `mode_i[5]`=1 and `par_err_i` was 1 in any cycle of the qualifying window, then `stat_o[2]` is set together with the selection bit. This happens even when `evt_en_i[2]`=0. `stat_o[2]` alone does not raise `irq_o`.
- R9: `evt_i` bit i, for i = 0 end-of-process, 1 bus reset, 2 data parity, 3 phase mismatch, 4 disconnect, sets `stat_o[3+i]` on the edge where it is 1, but only if `evt_en_i[i]`=1. End-of-process additionally requires `mode_i[1]`=1.
- R10: `irq_o` is 1 exactly when any of `stat_o[0]`, `stat_o[1]` or `stat_o[7:3]` is 1.
- R11: `rd_clr_i`=1 on an edge clears all status bits. A cause that sets on that same edge stays set.
- R12: `ext_rst_i` held for RST_HOLD_CYC consecutive edges clears all status on the last of those edges. A shorter assertion has no effect on `stat_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Filtered select, active high |
| bsy_i | input | 1 | Filtered busy, active high |
| io_i | input | 1 | Filtered I/O line, active high |
| par_err_i | input | 1 | Parity error seen on the bus data |
| id_i | input | ID_W | Data-bus ID bits |
| sel_en_i | input | ID_W | Select-enable mask |
| mode_i | input | 8 | Mode word; bit 1 DMA mode, bit 5 parity enable |
| evt_i | input | 5 | Event pulses: eop, bus reset, data parity, phase mismatch, disconnect |
| evt_en_i | input | 5 | Per-event interrupt enables |
| rd_clr_i | input | 1 | Host read of the clear address |
| ext_rst_i | input | 1 | External chip reset, active high |
| irq_o | output | 1 | Interrupt request |
| stat_o | output | 8 | Sticky status: sel, resel, sel parity, eop, bus reset, parity, phase, disconnect |

## Verification
A selection bit appears on the SETTLE_CYC-th rising edge after the qualifying inputs are applied. Event bits and the host clear act on the first edge, and the external clear acts on the RST_HOLD_CYC-th edge. `irq_o` follows the status combinationally. The driver changes inputs at a falling edge and steps exactly that many falling edges before it queues the expected status. The monitor compares shortly after that falling edge, where every register on the path has already updated. Boundary checks one cycle short of each count confirm that nothing fires early.

// File: rtl/scsi_sel_irq_pkg.sv
package scsi_sel_irq_pkg;
  localparam int N_EVT  = 5;
  localparam int N_STAT = 8;

  typedef enum int {
    ST_SEL    = 0,
    ST_RESEL  = 1,
    ST_SELPAR = 2,
    ST_EOP    = 3,
    ST_BUSRST = 4,
    ST_PAR    = 5,
    ST_PHASE  = 6,
    ST_DISC   = 7
  } stat_idx_e;

  localparam int EVT_BASE = ST_EOP;
  localparam int EVT_EOP  = 0;

  localparam int MODE_DMA_BIT = 1;
  localparam int MODE_PAR_BIT = 5;

  // status bits that drive the interrupt line
  localparam logic [N_STAT-1:0] IRQ_MASK = ~(N_STAT'(1) << ST_SELPAR);
endpackage

// File: rtl/scsi_hold_filter.sv
module scsi_hold_filter #(
  parameter int N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic held_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!in_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
  end

  assign held_o = in_i && (cnt_q == LAST);
endmodule

// File: rtl/scsi_sel_detect.sv
module scsi_sel_detect #(
  parameter int ID_W       = 8,
  parameter int SETTLE_CYC = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic            bsy_i,
  input  logic            io_i,
  input  logic            par_err_i,
  input  logic            par_en_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] sel_en_i,
  output logic            sel_set_o,
  output logic            resel_set_o,
  output logic            selpar_set_o
);
  logic id_hit, qual, settled, fire;
  logic armed_q, par_seen_q;

  assign id_hit = |(id_i & sel_en_i);
  assign qual   = sel_i && !bsy_i && id_hit;

  scsi_hold_filter #(.N(SETTLE_CYC)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (qual),
    .held_o (settled)
  );

  assign fire = settled && armed_q;

  // one detection per select assertion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b1;
    else if (!sel_i) armed_q <= 1'b1;
    else if (fire)   armed_q <= 1'b0;
  end

  // parity error seen anywhere in the current window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        par_seen_q <= 1'b0;
    else if (!qual)     par_seen_q <= 1'b0;
    else if (par_err_i) par_seen_q <= 1'b1;
  end

  assign sel_set_o    = fire && !io_i;
  assign resel_set_o  = fire && io_i;
  assign selpar_set_o = fire && par_en_i && (par_seen_q || par_err_i);
endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
  import scsi_sel_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_set_i,
  input  logic             resel_set_i,
  input  logic             selpar_set_i,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] evt_en_i,
  input  logic             dma_mode_i,
  input  logic             clr_i,
  output logic [N_STAT-1:0] stat_o,
  output logic             irq_o
);
  logic [N_STAT-1:0] set_vec;
  logic [N_STAT-1:0] stat_q;

  always_comb begin
    set_vec             = '0;
    set_vec[ST_SEL]     = sel_set_i;
    set_vec[ST_RESEL]   = resel_set_i;
    set_vec[ST_SELPAR]  = selpar_set_i;
  end

  logic [N_EVT-1:0] evt_hit;

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    if (i == EVT_EOP) begin : g_eop
      assign evt_hit[i] = evt_i[i] && evt_en_i[i] && dma_mode_i;
    end else begin : g_plain
      assign evt_hit[i] = evt_i[i] && evt_en_i[i];
    end
  end

  logic [N_STAT-1:0] set_all;
  assign set_all = set_vec | (N_STAT'(evt_hit) << EVT_BASE);

  // a cause arriving with the clear survives it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (clr_i ? '0 : stat_q) | set_all;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & IRQ_MASK);
endmodule

// File: rtl/scsi_sel_irq.sv
module scsi_sel_irq
  import scsi_sel_irq_pkg::*;
#(
  parameter int ID_W         = 8,
  parameter int SETTLE_CYC   = 8,
  parameter int RST_HOLD_CYC = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              bsy_i,
  input  logic              io_i,
  input  logic              par_err_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ID_W-1:0]   sel_en_i,
  input  logic [7:0]        mode_i,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic [N_EVT-1:0]  evt_en_i,
  input  logic              rd_clr_i,
  input  logic              ext_rst_i,
  output logic              irq_o,
  output logic [N_STAT-1:0] stat_o
);
  logic sel_set, resel_set, selpar_set;
  logic ext_clr;

  scsi_sel_detect #(.ID_W(ID_W), .SETTLE_CYC(SETTLE_CYC)) u_det (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_i        (sel_i),
    .bsy_i        (bsy_i),
    .io_i         (io_i),
    .par_err_i    (par_err_i),
    .par_en_i     (mode_i[MODE_PAR_BIT]),
    .id_i         (id_i),
    .sel_en_i     (sel_en_i),
    .sel_set_o    (sel_set),
    .resel_set_o  (resel_set),
    .selpar_set_o (selpar_set)
  );

  scsi_hold_filter #(.N(RST_HOLD_CYC)) u_ext_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (ext_rst_i),
    .held_o (ext_clr)
  );

  scsi_irq_status u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_set_i    (sel_set),
    .resel_set_i  (resel_set),
    .selpar_set_i (selpar_set),
    .evt_i        (evt_i),
    .evt_en_i     (evt_en_i),
    .dma_mode_i   (mode_i[MODE_DMA_BIT]),
    .clr_i        (rd_clr_i || ext_clr),
    .stat_o       (stat_o),
    .irq_o        (irq_o)
  );
endmodule

// File: rtl/scsi_sel_irq_chk.sv
module scsi_sel_irq_chk
  import scsi_sel_irq_pkg::*;
#(
  parameter int ID_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              bsy_i,
  input logic              io_i,
  input logic              par_err_i,
  input logic [ID_W-1:0]   id_i,
  input logic [ID_W-1:0]   sel_en_i,
  input logic [7:0]        mode_i,
  input logic [N_EVT-1:0]  evt_i,
  input logic [N_EVT-1:0]  evt_en_i,
  input logic              rd_clr_i,
  input logic              ext_rst_i,
  input logic              irq_o,
  input logic [N_STAT-1:0] stat_o
);
  a_r2_sel_needs_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[ST_SEL]) |-> $past(sel_i && !bsy_i && !io_i && |(id_i & sel_en_i)));

  a_r4_resel_needs_io: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[ST_RESEL]) |-> $past(sel_i && !bsy_i && io_i));

  a_r5_mask_zero_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_en_i == '0) |=> !$rose(stat_o[ST_SEL]) && !$rose(stat_o[ST_RESEL]));

  a_r8_selpar_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[ST_SELPAR]) |-> $past(mode_i[MODE_PAR_BIT]));

  a_r9_phase_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i[3] && evt_en_i[3]) |=> stat_o[ST_PHASE]);

  a_r11_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && evt_i == '0 && !sel_i) |=> (stat_o == '0) && !irq_o);
endmodule

bind scsi_sel_irq scsi_sel_irq_chk #(.ID_W(ID_W)) chk_i (.*);

// File: tb/scsi_sel_irq_tb_top.sv
`timescale 1ns/1ps
module scsi_sel_irq_tb_top;
  localparam int ID_W = 8;
  localparam int SETTLE = 8;
  localparam int RHOLD = 40;

  typedef struct {
    string      tag;
    logic [7:0] st;
    logic       irq;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sel_i = 0, bsy_i = 0, io_i = 0, par_err_i = 0;
  logic [ID_W-1:0] id_i = '0, sel_en_i = '0;
  logic [7:0] mode_i = '0;
  logic [4:0] evt_i = '0, evt_en_i = '0;
  logic rd_clr_i = 0, ext_rst_i = 0;
  logic irq_o;
  logic [7:0] stat_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  scsi_sel_irq #(.ID_W(ID_W), .SETTLE_CYC(SETTLE), .RST_HOLD_CYC(RHOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .bsy_i(bsy_i), .io_i(io_i),
    .par_err_i(par_err_i), .id_i(id_i), .sel_en_i(sel_en_i), .mode_i(mode_i),
    .evt_i(evt_i), .evt_en_i(evt_en_i), .rd_clr_i(rd_clr_i), .ext_rst_i(ext_rst_i),
    .irq_o(irq_o), .stat_o(stat_o)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(string tag, logic [7:0] st);
    exp_t e;
    e.tag = tag;
    e.st  = st;
    e.irq = |(st & 8'hFB);
    sb.push_back(e);
  endtask

  task automatic pulse_clr();
    rd_clr_i = 1; step(1); rd_clr_i = 0;
  endtask

  // monitor: compares queued expectations after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (stat_o !== e.st || irq_o !== e.irq) begin
          errors++;
          $display("FAIL %s: stat=%h irq=%b expected stat=%h irq=%b",
                   e.tag, stat_o, irq_o, e.st, e.irq);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1;
    step(1);
    expect_st("R1 reset state", 8'h00);

    // single-bit match, one cycle short then on time
    sel_en_i = 8'h04; id_i = 8'h84; sel_i = 1;
    step(SETTLE - 1);
    expect_st("R2 one cycle short of settle", 8'h00);
    step(1);
    expect_st("R2 R3 selection after settle", 8'h01);

    // still selected: clear and hold, no second detection
    pulse_clr();
    expect_st("R11 host clear", 8'h00);
    step(SETTLE + 2);
    expect_st("R7 no re-fire while select held", 8'h00);
    sel_i = 0; step(1); sel_i = 1;
    step(SETTLE);
    expect_st("R7 re-armed after select low", 8'h01);
    sel_i = 0; pulse_clr();

    // settle restart
    sel_i = 1;
    step(SETTLE - 1);
    bsy_i = 1; step(1); bsy_i = 0;
    step(SETTLE - 1);
    expect_st("R6 count restarted by busy", 8'h00);
    step(1);
    expect_st("R6 detection after restart", 8'h01);
    sel_i = 0; pulse_clr();

    // no overlap / multi-bit overlap
    sel_en_i = 8'h04; id_i = 8'h02; sel_i = 1;
    step(SETTLE + 3);
    expect_st("R3 no overlap", 8'h00);
    sel_i = 0; step(1);
    sel_en_i = 8'h0F; id_i = 8'hFF; sel_i = 1;
    step(SETTLE);
    expect_st("R3 multi-bit overlap", 8'h01);
    sel_i = 0; pulse_clr();

    // mask of zeros
    sel_en_i = 8'h00; id_i = 8'hFF; sel_i = 1;
    step(SETTLE + 4);
    expect_st("R5 zero mask blocks selection", 8'h00);
    sel_i = 0; step(1);

    // reselection
    sel_en_i = 8'h04; id_i = 8'h04; io_i = 1; sel_i = 1;
    step(SETTLE);
    expect_st("R4 reselection", 8'h02);
    sel_i = 0; io_i = 0; pulse_clr();

    // selection parity
    mode_i = 8'h20; evt_en_i = 5'h00; sel_i = 1; par_err_i = 1;
    step(1); par_err_i = 0;
    step(SETTLE - 1);
    expect_st("R8 selection parity latched", 8'h05);
    sel_i = 0; pulse_clr();
    mode_i = 8'h00; sel_i = 1; par_err_i = 1;
    step(1); par_err_i = 0;
    step(SETTLE - 1);
    expect_st("R8 parity ignored when disabled", 8'h01);
    sel_i = 0; pulse_clr();
    expect_st("R10 irq low after clear", 8'h00);

    // events
    evt_en_i = 5'h1F; mode_i = 8'h02;
    for (int i = 0; i < 5; i++) begin
      evt_i = 5'(1 << i); step(1); evt_i = 0;
      expect_st($sformatf("R9 R10 event %0d", i), 8'(1 << (3 + i)));
      pulse_clr();
    end
    mode_i = 8'h00;
    evt_i = 5'h01; step(1); evt_i = 0;
    expect_st("R9 eop gated by dma mode", 8'h00);
    mode_i = 8'h02; evt_en_i = 5'h17;
    evt_i = 5'h08; step(1); evt_i = 0;
    expect_st("R9 phase event disabled", 8'h00);
    evt_en_i = 5'h1F;

    // set wins over clear
    evt_i = 5'h01; step(1); evt_i = 0;
    expect_st("R9 eop set", 8'h08);
    evt_i = 5'h08; rd_clr_i = 1; step(1); evt_i = 0; rd_clr_i = 0;
    expect_st("R11 set beats clear", 8'h40);

    // external reset hold
    ext_rst_i = 1; step(RHOLD - 1); ext_rst_i = 0;
    expect_st("R12 short ext reset ignored", 8'h40);
    step(1);
    ext_rst_i = 1; step(RHOLD); ext_rst_i = 0;
    expect_st("R12 held ext reset clears", 8'h00);

    step(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule